// File: doc/BRIEF.md
# Packetized Block Stream Generator

This block produces a framed stream of test samples for a datapath that expects packets. It reads samples from a small waveform RAM and walks a window of that RAM that software bounds with a first and a last address. When it reaches the last address of the window it goes back to the first one. Samples are cut into packets of a programmable length. Between two packets the output stays idle for a programmable number of clock cycles. A programmable count of packets forms one sync period.

Each packet is tagged with a 64-bit block sequence number. The number starts from a loadable value and rises by one per packet. The first sample of the first packet in every sync period carries a sync flag. Generation starts in one of two ways: at once when the run bit is set, or on the next pulse-per-second input when the pulse-armed bit is set. When both bits are cleared, the packet in flight completes before the output stops.

Top module: `block_stream_gen`

## Requirements
- R1: After reset the registers read back as follows: control 0, packet length 256, packets per sync 781250, gap 80, window start 0, window end 255, and both sequence words 0. While reset is active and after it, out_valid stays low.
- R2: Registers sit at byte addresses 0x00 control (bit 0 run, bit 1 pulse-armed), 0x04 packet length (16 bits), 0x08 packets per sync (32 bits), 0x0C gap (16 bits), 0x10 window start (8 bits), 0x14 window end (8 bits), 0x18 sequence bits 31:0 and 0x1C sequence bits 63:32. A read returns the field zero-extended, and bits above the field width are dropped on write.
- R3: While both control bits are 0 the block emits nothing. Writing control bit 0 starts output without waiting for any external event, and the first sample is a start-of-packet.
- R4: With only control bit 1 set, no sample appears until pps is sampled high on a clock edge. The first sample, a start-of-packet, appears on the next edge. A pps pulse while packets are already flowing has no effect on the stream.
- R5: Each packet holds exactly the programmed number of consecutive valid samples. out_sop marks the first sample and out_eop the last. A length of 0 acts as 1.
- R6: Between the end-of-packet sample and the next start-of-packet sample there are exactly gap idle cycles. A gap of 0 gives back-to-back packets.
- R7: Sample n of a run is the RAM word at window start + (n mod (end - start + 1)). The window walk carries on across packet boundaries. Window start must not exceed window end.
- R8: The first packet of a run carries the sequence number {word 0x1C, word 0x18}. Each later packet carries the previous value plus one, with carry across all 64 bits and wrap-around at the top.
- R9: out_sync is high only on the start-of-packet sample of packets whose index within the run is a multiple of the packets-per-sync value.
- R10: Clearing both control bits in the middle of a packet lets that packet finish with its end-of-packet sample. No further sample follows.
- R11: A word written through the waveform port at an address is the value output for that address from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pps | input | 1 | Pulse-per-second start event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| wav_we | input | 1 | Waveform RAM write enable |
| wav_addr | input | ADDR_W | Waveform RAM write address |
| wav_wdata | input | DATA_W | Waveform RAM write data |
| out_valid | output | 1 | Sample valid |
| out_sop | output | 1 | First sample of a packet |
| out_eop | output | 1 | Last sample of a packet |
| out_sync | output | 1 | Start of a sync period |
| out_bsn | output | 64 | Block sequence number of the current packet |
| out_data | output | DATA_W | Sample value |

## Verification
Faults in the sample or packet counters show up at the ports within one packet. A wrong sample count moves out_eop and the next out_sop. A wrong gap count changes the number of idle cycles before the next out_sop. Faults in the address walk or the sequence counter change out_data or out_bsn on the next sample that depends on them, so they show within one window length or one packet. A packets-per-sync fault only appears when out_sync lands on the wrong packet, so the bench runs more than one full sync period. Start and stop faults show up in the few cycles around a pps pulse or a control write.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

   localparam int BSN_W  = 64;
   localparam int WORD_W = 32;
   localparam int RADR_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2,
      ST_GAP   = 2'd3
   } bsg_state_t;

   localparam logic [2:0] IX_CTRL  = 3'd0;
   localparam logic [2:0] IX_LEN   = 3'd1;
   localparam logic [2:0] IX_NSYNC = 3'd2;
   localparam logic [2:0] IX_GAP   = 3'd3;
   localparam logic [2:0] IX_LO    = 3'd4;
   localparam logic [2:0] IX_HI    = 3'd5;
   localparam logic [2:0] IX_SEQL  = 3'd6;
   localparam logic [2:0] IX_SEQH  = 3'd7;

endpackage

// File: rtl/bsg_regs.sv
module bsg_regs
   import bsg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int LEN_W    = 16,
   parameter int SYNC_W   = 32,
   parameter int LEN_RST  = 256,
   parameter int GAP_RST  = 80,
   parameter int SYNC_RST = 781250
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [RADR_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic [1:0]          ctrl,
   output logic [LEN_W-1:0]    pkt_len,
   output logic [SYNC_W-1:0]   nsync,
   output logic [LEN_W-1:0]    gap_len,
   output logic [ADDR_W-1:0]   win_lo,
   output logic [ADDR_W-1:0]   win_hi,
   output logic [BSN_W-1:0]    seq_init
);

   logic [2:0]        idx;
   logic [WORD_W-1:0] seq_lo_q, seq_hi_q;

   assign idx      = reg_addr[4:2];
   assign seq_init = {seq_hi_q, seq_lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         pkt_len  <= LEN_W'(LEN_RST);
         nsync    <= SYNC_W'(SYNC_RST);
         gap_len  <= LEN_W'(GAP_RST);
         win_lo   <= '0;
         win_hi   <= '1;
         seq_lo_q <= '0;
         seq_hi_q <= '0;
      end else if (reg_wr) begin
         case (idx)
            IX_CTRL:  ctrl     <= reg_wdata[1:0];
            IX_LEN:   pkt_len  <= reg_wdata[LEN_W-1:0];
            IX_NSYNC: nsync    <= reg_wdata[SYNC_W-1:0];
            IX_GAP:   gap_len  <= reg_wdata[LEN_W-1:0];
            IX_LO:    win_lo   <= reg_wdata[ADDR_W-1:0];
            IX_HI:    win_hi   <= reg_wdata[ADDR_W-1:0];
            IX_SEQL:  seq_lo_q <= reg_wdata;
            default:  seq_hi_q <= reg_wdata;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IX_CTRL:  reg_rdata = WORD_W'(ctrl);
         IX_LEN:   reg_rdata = WORD_W'(pkt_len);
         IX_NSYNC: reg_rdata = WORD_W'(nsync);
         IX_GAP:   reg_rdata = WORD_W'(gap_len);
         IX_LO:    reg_rdata = WORD_W'(win_lo);
         IX_HI:    reg_rdata = WORD_W'(win_hi);
         IX_SEQL:  reg_rdata = seq_lo_q;
         default:  reg_rdata = seq_hi_q;
      endcase
   end

endmodule

// File: rtl/bsg_wave_mem.sv
module bsg_wave_mem #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/bsg_seq.sv
module bsg_seq
   import bsg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LEN_W  = 16,
   parameter int SYNC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ctrl,
   input  logic              pps,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic [SYNC_W-1:0] nsync,
   input  logic [LEN_W-1:0]  gap_len,
   input  logic [ADDR_W-1:0] win_lo,
   input  logic [ADDR_W-1:0] win_hi,
   input  logic [BSN_W-1:0]  seq_init,
   output logic              req_valid,
   output logic              req_sop,
   output logic              req_eop,
   output logic              req_sync,
   output logic [BSN_W-1:0]  req_bsn,
   output logic [ADDR_W-1:0] rd_addr
);

   bsg_state_t        state;
   logic [LEN_W-1:0]  smp_cnt;
   logic [LEN_W-1:0]  gap_cnt;
   logic [SYNC_W-1:0] pkt_cnt;
   logic [BSN_W-1:0]  bsn;
   logic              last_smp, last_pkt, gap_done, enabled;
   logic [ADDR_W-1:0] nxt_addr;

   // a length of zero compares as one sample
   assign last_smp = ({1'b0, smp_cnt} + 1'b1) >= {1'b0, pkt_len};
   assign last_pkt = ({1'b0, pkt_cnt} + 1'b1) >= {1'b0, nsync};
   assign gap_done = gap_cnt >= gap_len;
   assign enabled  = |ctrl;
   assign nxt_addr = (rd_addr == win_hi) ? win_lo : rd_addr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         smp_cnt <= '0;
         gap_cnt <= '0;
         pkt_cnt <= '0;
         bsn     <= '0;
         rd_addr <= '0;
      end else begin
         case (state)
            ST_IDLE, ST_ARMED: begin
               if (ctrl[0] || (state == ST_ARMED && pps)) begin
                  state   <= ST_RUN;
                  smp_cnt <= '0;
                  pkt_cnt <= '0;
                  bsn     <= seq_init;
                  rd_addr <= win_lo;
               end else if (ctrl[1]) begin
                  state <= ST_ARMED;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_RUN: begin
               rd_addr <= nxt_addr;
               if (last_smp) begin
                  smp_cnt <= '0;
                  bsn     <= bsn + 1'b1;
                  pkt_cnt <= last_pkt ? '0 : pkt_cnt + 1'b1;
                  if (!enabled) begin
                     state <= ST_IDLE;
                  end else if (gap_len != '0) begin
                     state   <= ST_GAP;
                     gap_cnt <= LEN_W'(1);
                  end
               end else begin
                  smp_cnt <= smp_cnt + 1'b1;
               end
            end
            default: begin
               if (gap_done) state <= enabled ? ST_RUN : ST_IDLE;
               else          gap_cnt <= gap_cnt + 1'b1;
            end
         endcase
      end
   end

   assign req_valid = (state == ST_RUN);
   assign req_sop   = req_valid && (smp_cnt == '0);
   assign req_eop   = req_valid && last_smp;
   assign req_sync  = req_sop && (pkt_cnt == '0);
   assign req_bsn   = bsn;

   // R4: an armed block stays out of the run state until pps or the run bit
   a_r4_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_ARMED && !$past(pps) && !$past(ctrl[0])) |-> state != ST_RUN);

   // R8: the sequence number advances by one at each packet end
   a_r8_bsn_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_eop)) |-> bsn == $past(bsn) + 1'b1);

endmodule

// File: rtl/block_stream_gen.sv
module block_stream_gen
   import bsg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int LEN_W    = 16,
   parameter int SYNC_W   = 32,
   parameter int LEN_RST  = 256,
   parameter int GAP_RST  = 80,
   parameter int SYNC_RST = 781250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pps,
   input  logic              reg_wr,
   input  logic [4:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              wav_we,
   input  logic [ADDR_W-1:0] wav_addr,
   input  logic [DATA_W-1:0] wav_wdata,
   output logic              out_valid,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_sync,
   output logic [63:0]       out_bsn,
   output logic [DATA_W-1:0] out_data
);

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 1..12");
      end
      if (LEN_W < 1 || LEN_W > WORD_W || SYNC_W < 1 || SYNC_W > WORD_W) begin : g_bad_cnt
         $error("counter widths must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [1:0]        ctrl;
   logic [LEN_W-1:0]  pkt_len, gap_len;
   logic [SYNC_W-1:0] nsync;
   logic [ADDR_W-1:0] win_lo, win_hi, rd_addr;
   logic [BSN_W-1:0]  seq_init, req_bsn;
   logic              req_valid, req_sop, req_eop, req_sync;

   bsg_regs #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W),
      .LEN_RST(LEN_RST), .GAP_RST(GAP_RST), .SYNC_RST(SYNC_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl(ctrl),
      .pkt_len(pkt_len), .nsync(nsync), .gap_len(gap_len),
      .win_lo(win_lo), .win_hi(win_hi), .seq_init(seq_init)
   );

   bsg_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .pps(pps),
      .pkt_len(pkt_len), .nsync(nsync), .gap_len(gap_len),
      .win_lo(win_lo), .win_hi(win_hi), .seq_init(seq_init),
      .req_valid(req_valid), .req_sop(req_sop), .req_eop(req_eop),
      .req_sync(req_sync), .req_bsn(req_bsn), .rd_addr(rd_addr)
   );

   bsg_wave_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .we(wav_we), .waddr(wav_addr), .wdata(wav_wdata),
      .raddr(rd_addr), .rdata(out_data)
   );

   // framing flags are registered to line up with the RAM read stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_sync  <= 1'b0;
         out_bsn   <= '0;
      end else begin
         out_valid <= req_valid;
         out_sop   <= req_sop;
         out_eop   <= req_eop;
         out_sync  <= req_sync;
         out_bsn   <= req_bsn;
      end
   end

   // R5: framing flags only on valid samples
   a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sop || out_eop) |-> out_valid);

   // R9: sync only on a start of packet
   a_r9_sync_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
      out_sync |-> out_sop);

   // R3: any burst of valid samples opens with a start of packet
   a_r3_start_at_sop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_sop);

   // R10: the stream only goes idle after an end of packet
   a_r10_stop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_eop));

   // R8: the sequence number holds for the whole packet
   a_r8_bsn_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> $stable(out_bsn));

endmodule

// File: tb/tb_block_stream_gen.sv
module tb_block_stream_gen;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;

   typedef struct packed {
      logic        wr;
      logic [4:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
   } vec_t;

   // reset values (R1) then masked write/readback at each offset (R2)
   localparam vec_t TBL [16] = '{
      '{1'b0, 5'h00, 32'h0,          32'd0},
      '{1'b0, 5'h04, 32'h0,          32'd256},
      '{1'b0, 5'h08, 32'h0,          32'd781250},
      '{1'b0, 5'h0C, 32'h0,          32'd80},
      '{1'b0, 5'h10, 32'h0,          32'd0},
      '{1'b0, 5'h14, 32'h0,          32'd255},
      '{1'b0, 5'h18, 32'h0,          32'd0},
      '{1'b0, 5'h1C, 32'h0,          32'd0},
      '{1'b1, 5'h04, 32'hABCD0004,   32'd4},
      '{1'b1, 5'h08, 32'h00000003,   32'd3},
      '{1'b1, 5'h0C, 32'h12340002,   32'd2},
      '{1'b1, 5'h10, 32'hFFFFFF05,   32'd5},
      '{1'b1, 5'h14, 32'h00000007,   32'd7},
      '{1'b1, 5'h18, 32'hFFFFFFFE,   32'hFFFFFFFE},
      '{1'b1, 5'h1C, 32'h00000001,   32'h00000001},
      '{1'b1, 5'h00, 32'hFFFFFFFC,   32'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pps = 1'b0;
   logic              reg_wr = 1'b0;
   logic [4:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              wav_we = 1'b0;
   logic [ADDR_W-1:0] wav_addr = '0;
   logic [DATA_W-1:0] wav_wdata = '0;
   logic              out_valid, out_sop, out_eop, out_sync;
   logic [63:0]       out_bsn;
   logic [DATA_W-1:0] out_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // monitor state and the expected configuration
   bit          mon_on = 1'b0;
   int          mon_k = 0, mon_cyc = 0, mon_last = 0;
   bit          mon_last_eop = 1'b0;
   int          e_len = 1, e_nsync = 1, e_gap = 0, e_lo = 0, e_hi = 0;
   logic [63:0] e_bsn0 = '0;
   int          m_pkt, m_pos;

   always #(CLK_PERIOD/2) clk = ~clk;

   block_stream_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .pps(pps),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wav_we(wav_we), .wav_addr(wav_addr), .wav_wdata(wav_wdata),
      .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync),
      .out_bsn(out_bsn), .out_data(out_data)
   );

   function automatic logic [31:0] wav_val(input int a);
      return 32'hC0DE0000 + 32'(a * 3);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // stream monitor: R5 R6 R7 R8 R9 R11 on every sample
   always @(negedge clk) begin
      if (mon_on) begin
         mon_cyc++;
         if (out_valid) begin
            m_pkt = mon_k / e_len;
            m_pos = mon_k % e_len;
            chk("R5 sop", 64'(out_sop), 64'(m_pos == 0));
            chk("R5 eop", 64'(out_eop), 64'(m_pos == e_len - 1));
            chk("R7/R11 data", 64'(out_data), 64'(wav_val(e_lo + mon_k % (e_hi - e_lo + 1))));
            chk("R8 bsn", out_bsn, e_bsn0 + 64'(m_pkt));
            chk("R9 sync", 64'(out_sync), 64'(m_pos == 0 && (m_pkt % e_nsync) == 0));
            if (mon_k > 0) begin
               if (m_pos == 0) chk("R6 gap", 64'(mon_cyc - mon_last - 1), 64'(e_gap));
               else            chk("R6 contiguous", 64'(mon_cyc - mon_last - 1), 64'd0);
            end
            mon_last     = mon_cyc;
            mon_last_eop = out_eop;
            mon_k++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (4) @(negedge clk);
      chk("R1 valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      repeat (6) @(negedge clk);
      chk("R3 idle when disabled", 64'(mon_k), 64'd0);
      chk("R1 valid after reset", 64'(out_valid), 64'd0);

      // register table
      for (int i = 0; i < 16; i++) begin
         if (TBL[i].wr) reg_write(TBL[i].addr, TBL[i].wdata);
         reg_read(TBL[i].addr, rd);
         chk(TBL[i].wr ? "R2 readback" : "R1 reset value", 64'(rd), 64'(TBL[i].exp));
      end

      // fill waveform RAM (R11)
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         wav_we = 1'b1; wav_addr = ADDR_W'(a); wav_wdata = wav_val(a);
      end
      @(negedge clk);
      wav_we = 1'b0;

      // immediate run: len 4, 3 per sync, gap 2, window 5..7, carry in bsn
      e_len = 4; e_nsync = 3; e_gap = 2; e_lo = 5; e_hi = 7;
      e_bsn0 = 64'h00000001_FFFFFFFE;
      mon_k = 0;
      reg_write(5'h00, 32'd1);
      for (int i = 0; i < 2000 && mon_k < 26; i++) @(negedge clk);
      chk("R3 run started", 64'(mon_k >= 26), 64'd1);
      for (int i = 0; i < 200 && !(out_valid && out_sop); i++) @(negedge clk);
      reg_write(5'h00, 32'd0);
      repeat (30) @(negedge clk);
      chk("R10 whole packets", 64'(mon_k % 4), 64'd0);
      chk("R10 ends on eop", 64'(mon_last_eop), 64'd1);
      chk("R10 stopped", 64'(mon_cyc - mon_last >= 20), 64'd1);

      // pulse-armed start (R4)
      mon_k = 0;
      reg_write(5'h00, 32'd2);
      repeat (10) @(negedge clk);
      chk("R4 waits for pps", 64'(mon_k), 64'd0);
      pps = 1'b1;
      @(negedge clk);
      pps = 1'b0;
      chk("R4 not yet valid", 64'(out_valid), 64'd0);
      @(negedge clk);
      chk("R4 first sample", 64'({out_valid, out_sop}), 64'd3);
      for (int i = 0; i < 200 && mon_k < 7; i++) @(negedge clk);
      pps = 1'b1;
      @(negedge clk);
      pps = 1'b0;
      for (int i = 0; i < 500 && mon_k < 18; i++) @(negedge clk);
      reg_write(5'h00, 32'd0);
      repeat (30) @(negedge clk);
      chk("R4 pps ignored while running", 64'(mon_k % 4), 64'd0);

      // length 0 acts as 1, gap 0, one-word window, 64-bit wrap
      reg_write(5'h04, 32'd0);
      reg_write(5'h08, 32'd2);
      reg_write(5'h0C, 32'd0);
      reg_write(5'h10, 32'd9);
      reg_write(5'h14, 32'd9);
      reg_write(5'h18, 32'hFFFFFFFF);
      reg_write(5'h1C, 32'hFFFFFFFF);
      e_len = 1; e_nsync = 2; e_gap = 0; e_lo = 9; e_hi = 9;
      e_bsn0 = 64'hFFFFFFFF_FFFFFFFF;
      mon_k = 0;
      reg_write(5'h00, 32'd1);
      for (int i = 0; i < 500 && mon_k < 12; i++) @(negedge clk);
      reg_write(5'h00, 32'd0);
      repeat (20) @(negedge clk);
      chk("R5 zero length runs", 64'(mon_k >= 12), 64'd1);
      chk("R10 stopped after single", 64'(mon_cyc - mon_last >= 15), 64'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule